// File: doc/BRIEF.md
# Aliased Byte, Register-Bank and Bit Data RAM

This block is the 128-byte internal data store of an 8-bit controller core. One storage array is reached three ways. A plain byte access uses a 7-bit address from 00h to 7Fh. A working-register access takes a 3-bit register number and places it in one of four eight-byte banks at the bottom of the array. A single-bit access reads, sets or clears one of 128 flags packed into the sixteen bytes from 20h to 2Fh. The bytes from 30h upward are plain storage and have no other view.

Each cycle the core issues one command on `cmd`, with an address operand and write data. Byte and register reads return data one cycle later with a valid strobe. A bit read returns the addressed bit one cycle later on a 1-bit output. A bit set or clear is done inside the block as a read of the containing byte followed by a write of the changed byte. `busy` is high during the write cycle, and any command issued while it is high is dropped. The bank in use is held in a 2-bit register. A dedicated command loads it, and reset returns it to bank 0.

Top module: `alias_ram`

## Requirements
- R1: While reset is asserted, `busy`, `rdValid` and `bitValid` are low. After reset every byte reads 00h.
- R2: `cmd`=2 writes `wrData` to byte `addr`. `cmd`=1 returns that byte on `rdData`, with `rdValid` high, on the cycle after the command. `rdValid` is low on every other cycle.
- R3: `cmd`=8 loads the bank register from `wrData[1:0]`. `cmd`=4 writes `wrData` and `cmd`=3 reads register `addr[2:0]`. Either one reaches byte address bank*8 + `addr[2:0]`, and a read returns its data like a byte read.
- R4: After reset the bank register is 0, so register n is byte n.
- R5: `cmd`=5 with bit number b on `addr` returns bit (b mod 8) of byte 20h + (b div 8). The bit appears on `bitOut`, with `bitValid` high, on the cycle after the command.
- R6: `cmd`=6 forces the addressed bit to 1 and `cmd`=7 forces it to 0. The other seven bits of that byte are unchanged.
- R7: An accepted set or clear raises `busy` for exactly the next cycle. Any command presented during that cycle is ignored.
- R8: A byte write in 20h to 2Fh is seen by a bit read issued on the very next cycle. A completed bit set or clear is seen by the next byte read.
- R9: Register and bit operations never change bytes 30h to 7Fh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cmd | input | 4 | Command: 0 idle, 1 byte read, 2 byte write, 3 register read, 4 register write, 5 bit read, 6 bit set, 7 bit clear, 8 bank load |
| addr | input | 7 | Byte address, register number (low 3 bits) or bit number |
| wrData | input | 8 | Write data. Bits 1:0 carry the bank for a bank load |
| rdData | output | 8 | Byte or register read data |
| rdValid | output | 1 | `rdData` is valid this cycle |
| bitOut | output | 1 | Bit read result |
| bitValid | output | 1 | `bitOut` is valid this cycle |
| busy | output | 1 | A bit write is in progress. Commands are dropped |

## Verification
The bench sweeps every byte, every register in every bank, and all 128 bit numbers, checking each result against a byte-array model. A wrong bank mapping shows up as a register landing in a neighbouring bank or in the wrong row. A wrong bit-row or bit-position calculation shows up in the bit sweep, for example bit 25h read from the wrong byte or the wrong lane. Each set or clear toggles the current bit and then reads the whole byte, so a write that damages neighbouring bits is caught. A byte write to the same row is driven during the busy cycle; if it is not dropped, that byte is corrupted. Back-to-back byte-write then bit-read pairs catch any stale copy of the row, and a final read of 30h to 7Fh catches writes that stray into general storage.

// File: rtl/alias_ram_pkg.sv
package alias_ram_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 7;
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int BANK_W    = 2;
  localparam int REG_W     = 3;
  localparam int LANE_W    = $clog2(DATA_W);
  localparam int BIT_BASE  = 32;
  localparam int CMD_W     = 4;

  localparam logic [CMD_W-1:0] OP_IDLE    = 4'd0;
  localparam logic [CMD_W-1:0] OP_BYTE_RD = 4'd1;
  localparam logic [CMD_W-1:0] OP_BYTE_WR = 4'd2;
  localparam logic [CMD_W-1:0] OP_REG_RD  = 4'd3;
  localparam logic [CMD_W-1:0] OP_REG_WR  = 4'd4;
  localparam logic [CMD_W-1:0] OP_BIT_RD  = 4'd5;
  localparam logic [CMD_W-1:0] OP_BIT_SET = 4'd6;
  localparam logic [CMD_W-1:0] OP_BIT_CLR = 4'd7;
  localparam logic [CMD_W-1:0] OP_BANK    = 4'd8;

  typedef struct packed {
    logic              byteRead;
    logic              byteWrite;
    logic              useBank;
    logic              bitRead;
    logic              rmwFetch;
    logic              rmwStore;
    logic              rmwVal;
    logic [ADDR_W-1:0] rmwBit;
    logic              bankLoad;
  } strobe_t;
endpackage

// File: rtl/alias_ram_ctl.sv
module alias_ram_ctl
  import alias_ram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb,
  output logic              busy
);
  logic              pend;
  logic              pendVal;
  logic [ADDR_W-1:0] pendBit;
  logic              accept;
  logic              isRmw;

  assign accept = !pend;
  assign isRmw  = (cmd == OP_BIT_SET) || (cmd == OP_BIT_CLR);
  assign busy   = pend;

  always_comb begin
    stb = '0;
    if (accept) begin
      case (cmd)
        OP_BYTE_RD: stb.byteRead = 1'b1;
        OP_BYTE_WR: stb.byteWrite = 1'b1;
        OP_REG_RD: begin
          stb.byteRead = 1'b1;
          stb.useBank  = 1'b1;
        end
        OP_REG_WR: begin
          stb.byteWrite = 1'b1;
          stb.useBank   = 1'b1;
        end
        OP_BIT_RD:  stb.bitRead = 1'b1;
        OP_BIT_SET, OP_BIT_CLR: stb.rmwFetch = 1'b1;
        OP_BANK:    stb.bankLoad = 1'b1;
        default: ;
      endcase
    end else begin
      stb.rmwStore = 1'b1;
      stb.rmwVal   = pendVal;
      stb.rmwBit   = pendBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend    <= 1'b0;
      pendVal <= 1'b0;
      pendBit <= '0;
    end else begin
      pend <= accept && isRmw;
      if (accept && isRmw) begin
        pendVal <= (cmd == OP_BIT_SET);
        pendBit <= addr;
      end
    end
  end
endmodule

// File: rtl/alias_ram_dp.sv
module alias_ram_dp
  import alias_ram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              bitOut,
  output logic              bitValid
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [BANK_W-1:0] bank;
  logic [DATA_W-1:0] holdByte;
  logic [ADDR_W-1:0] rowAddr;
  logic [DATA_W-1:0] rowData;
  logic [DATA_W-1:0] laneMask;
  logic [DATA_W-1:0] mergedByte;

  function automatic logic [ADDR_W-1:0] bitRow(input logic [ADDR_W-1:0] b);
    return ADDR_W'(BIT_BASE) + ADDR_W'(b >> LANE_W);
  endfunction

  always_comb begin
    if (stb.rmwStore)
      rowAddr = bitRow(stb.rmwBit);
    else if (stb.bitRead || stb.rmwFetch)
      rowAddr = bitRow(addr);
    else if (stb.useBank)
      rowAddr = {bank, addr[REG_W-1:0]};
    else
      rowAddr = addr;
  end

  assign rowData    = mem[rowAddr];
  assign laneMask   = DATA_W'(1) << stb.rmwBit[LANE_W-1:0];
  assign mergedByte = stb.rmwVal ? (holdByte | laneMask) : (holdByte & ~laneMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      bank     <= '0;
      holdByte <= '0;
      rdData   <= '0;
      rdValid  <= 1'b0;
      bitOut   <= 1'b0;
      bitValid <= 1'b0;
    end else begin
      rdValid  <= stb.byteRead;
      bitValid <= stb.bitRead;
      if (stb.byteRead) rdData <= rowData;
      if (stb.bitRead)  bitOut <= rowData[addr[LANE_W-1:0]];
      if (stb.rmwFetch) holdByte <= rowData;
      if (stb.byteWrite) mem[rowAddr] <= wrData;
      if (stb.rmwStore)  mem[rowAddr] <= mergedByte;
      if (stb.bankLoad)  bank <= wrData[BANK_W-1:0];
    end
  end
endmodule

// File: rtl/alias_ram.sv
module alias_ram
  import alias_ram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              bitOut,
  output logic              bitValid,
  output logic              busy
);
  strobe_t stb;

  alias_ram_ctl uCtl (
    .clk  (clk),
    .rstN (rstN),
    .cmd  (cmd),
    .addr (addr),
    .stb  (stb),
    .busy (busy)
  );

  alias_ram_dp uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .addr     (addr),
    .wrData   (wrData),
    .rdData   (rdData),
    .rdValid  (rdValid),
    .bitOut   (bitOut),
    .bitValid (bitValid)
  );
endmodule

// File: rtl/alias_ram_chk.sv
module alias_ram_chk
  import alias_ram_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [CMD_W-1:0] cmd,
  input logic             rdValid,
  input logic             bitValid,
  input logic             busy
);
  logic rdCmd, bitRdCmd, rmwCmd;
  assign rdCmd    = (cmd == OP_BYTE_RD) || (cmd == OP_REG_RD);
  assign bitRdCmd = (cmd == OP_BIT_RD);
  assign rmwCmd   = (cmd == OP_BIT_SET) || (cmd == OP_BIT_CLR);

  assert_busy_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  assert_busy_after_rmw_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rmwCmd && !busy) |=> busy);

  assert_read_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdCmd && !busy) |=> rdValid);

  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(rdCmd && !busy) |=> !rdValid);

  assert_bit_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    (bitRdCmd && !busy) |=> (bitValid && !rdValid));
endmodule

bind alias_ram alias_ram_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cmd      (cmd),
  .rdValid  (rdValid),
  .bitValid (bitValid),
  .busy     (busy)
);

// File: tb/sim_alias_ram.sv
`timescale 1ns/1ps
module sim_alias_ram;
  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] cmd;
  logic [6:0] addr;
  logic [7:0] wrData;
  logic [7:0] rdData;
  logic       rdValid, bitOut, bitValid, busy;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] model [128];

  always #10 clk = ~clk;

  alias_ram u0 (
    .clk(clk), .rstN(rstN), .cmd(cmd), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .bitOut(bitOut),
    .bitValid(bitValid), .busy(busy)
  );

  task automatic check(input string req, input int actual, input int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
    end
  endtask

  task automatic doCmd(input logic [3:0] c, input logic [6:0] a, input logic [7:0] d);
    cmd = c; addr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    cmd = 4'd0;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; cmd = 4'd0; addr = '0; wrData = '0;
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 rdValid", rdValid, 0);
    check("R1 bitValid", bitValid, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: every byte cleared
    for (int a = 0; a < 128; a++) begin
      doCmd(4'd1, 7'(a), 8'h00);
      check("R1 rdValid", rdValid, 1);
      check("R1 byte", rdData, 0);
    end
    doCmd(4'd0, 7'd0, 8'h00);
    check("R2 idle rdValid", rdValid, 0);

    // R4: default bank is 0
    doCmd(4'd4, 7'd5, 8'hA5); model[5] = 8'hA5;
    doCmd(4'd1, 7'd5, 8'h00);
    check("R4 reg5 in bank0", rdData, 8'hA5);

    // R2: fill and read back all bytes
    for (int a = 0; a < 128; a++) begin
      model[a] = 8'((a * 37 + 5) & 8'hFF);
      doCmd(4'd2, 7'(a), model[a]);
    end
    for (int a = 0; a < 128; a++) begin
      doCmd(4'd1, 7'(a), 8'h00);
      check("R2 byte", rdData, model[a]);
    end

    // R3: registers in every bank
    for (int bk = 0; bk < 4; bk++) begin
      doCmd(4'd8, 7'd0, 8'(bk));
      for (int n = 0; n < 8; n++) begin
        model[bk*8+n] = 8'(8'hC0 ^ (bk * 16 + n * 3));
        doCmd(4'd4, 7'(n), model[bk*8+n]);
      end
    end
    for (int bk = 0; bk < 4; bk++) begin
      doCmd(4'd8, 7'h7C, 8'(8'hFC | bk));
      for (int n = 0; n < 8; n++) begin
        doCmd(4'd3, 7'(n), 8'h00);
        check("R3 reg read", rdData, model[bk*8+n]);
        doCmd(4'd1, 7'(bk*8+n), 8'h00);
        check("R3 byte alias", rdData, model[bk*8+n]);
      end
    end

    // R5: every bit number
    for (int b = 0; b < 128; b++) begin
      doCmd(4'd5, 7'(b), 8'h00);
      check("R5 bitValid", bitValid, 1);
      check("R5 bit", bitOut, model[32 + b/8][b%8]);
    end

    // R6 R7 R8: toggle each bit, hammer the row during busy
    for (int b = 0; b < 128; b++) begin
      logic v;
      v = ~model[32 + b/8][b%8];
      doCmd(v ? 4'd6 : 4'd7, 7'(b), 8'h00);
      check("R7 busy high", busy, 1);
      doCmd(4'd2, 7'(32 + b/8), 8'(~model[32 + b/8]));
      check("R7 busy low", busy, 0);
      model[32 + b/8][b%8] = v;
      doCmd(4'd1, 7'(32 + b/8), 8'h00);
      check("R6 R8 row after bit op", rdData, model[32 + b/8]);
    end

    // R8: byte write seen by bit reads on the next cycle
    for (int r = 0; r < 16; r++) begin
      model[32+r] = 8'(8'h5A ^ (r * 17));
      doCmd(4'd2, 7'(32 + r), model[32+r]);
      for (int k = 0; k < 8; k++) begin
        doCmd(4'd5, 7'(r*8 + k), 8'h00);
        check("R8 bit after byte write", bitOut, model[32+r][k]);
      end
    end

    // R9: general storage untouched
    for (int a = 48; a < 128; a++) begin
      doCmd(4'd1, 7'(a), 8'h00);
      check("R9 general byte", rdData, model[a]);
    end

    finishRun();
  end
endmodule